// File: doc/BRIEF.md
# NAND Read Strobe Timing Sequencer

This block drives the control pins for a single asynchronous byte read from a NAND flash device. A one-cycle request with an address starts an access. The block then drives chip-select low through three ordered phases: setup, strobe and hold. Output-enable is held low only during the strobe phase. The address-latch and command-latch lines follow fixed address bits for the whole access. The byte on the 8-bit data bus is registered on the last clock edge of the strobe phase and is presented together with a one-cycle done pulse.

Each phase width comes from a software field, encoded as the cycle count minus one. A write request has no strobes of its own here; it only hands the bus over through a one-cycle grant pulse. When the access before the write was a read, the grant is delayed by a programmable turnaround gap, so the write path cannot drive the bus while the flash is still releasing it. All fields are sampled when a request is accepted.

Top module: `nand_rd_seq`

## Requirements
- R1: While `rst_ni` is low, `cs_no` and `oe_no` are 1 and `busy_o`, `done_o` and `wr_go_o` are 0.
- R2: A read request accepted at a clock edge drives `cs_no` low from the next cycle. The setup phase follows for `setup_cfg_i`+1 cycles, with `oe_no` high.
- R3: The strobe phase follows the setup phase directly and lasts `strobe_cfg_i`+1 cycles. `oe_no` is low only during this phase and only while `cs_no` is low.
- R4: The hold phase follows for `hold_cfg_i`+1 cycles with `oe_no` high. After it `cs_no` returns to 1, so the low time of `cs_no` is the sum of the three phase widths.
- R5: `flash_d_i` is registered on the last edge of the strobe phase. `done_o` is high for exactly one cycle, the first hold cycle, and `rdata_o` carries the captured byte in that cycle.
- R6: `ale_o` equals address bit 1 and `cle_o` equals address bit 2 of the accepted read. Both hold steady for the whole time `cs_no` is low.
- R7: `busy_o` is high from the cycle after acceptance through the last hold cycle. A request that arrives while `busy_o` is high is ignored.
- R8: A write request that follows a read makes `busy_o` high for `turn_cfg_i`+1 cycles. The cycle after those, `wr_go_o` pulses for one cycle, with `cs_no` high.
- R9: A write request after reset or after another write pulses `wr_go_o` in the next cycle with no gap, and `busy_o` stays low.
- R10: A read request accepted in the first idle cycle after a read starts its setup phase in the next cycle, with no turnaround gap.
- R11: Changes to the configuration fields after a request is accepted do not change the timing of that access.
- R12: The extreme field values work: all zero gives one cycle per phase, and all ones gives 16, 64 and 8 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle access request, taken only while idle |
| req_wr_i | input | 1 | 1: request is a write hand-over, 0: read |
| addr_i | input | 8 | Access address; bits 1 and 2 feed the latch lines |
| setup_cfg_i | input | 4 | Setup width minus one |
| strobe_cfg_i | input | 6 | Strobe width minus one |
| hold_cfg_i | input | 3 | Hold width minus one |
| turn_cfg_i | input | 2 | Read-to-write gap minus one |
| flash_d_i | input | 8 | Flash data bus |
| cs_no | output | 1 | Chip-select, active low |
| oe_no | output | 1 | Output-enable, active low |
| ale_o | output | 1 | Address-latch enable |
| cle_o | output | 1 | Command-latch enable |
| busy_o | output | 1 | Access or turnaround in progress |
| done_o | output | 1 | One-cycle pulse with the captured byte |
| rdata_o | output | 8 | Captured read byte |
| wr_go_o | output | 1 | One-cycle grant for the write path |

## Verification
The bench models the flash so that it returns the byte only while output-enable is low and returns 0xFF otherwise. A design that captured one edge late would therefore deliver 0xFF. Each phase width is checked at both ends of the encoding. A design that dropped the minus-one offset would give chip-select windows one cycle short per phase. The bench issues reads back to back, writes after reads and after writes, and a write right after reset. A design that always inserted the gap, or never did, shows a wrong grant cycle. The configuration is inverted in mid-access and a request is poked while busy. A design that reused live fields or accepted the stray request would show wrong window lengths or an unexpected chip-select window.

// File: rtl/nand_rd_pkg.sv
`timescale 1ns/1ps
package nand_rd_pkg;
  localparam int unsigned SETUP_FW  = 4;
  localparam int unsigned STROBE_FW = 6;
  localparam int unsigned HOLD_FW   = 3;
  localparam int unsigned TURN_FW   = 2;
  localparam int unsigned DATA_W    = 8;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_TURN   = 3'd4
  } phase_e;

  // fields used after the accept cycle
  typedef struct packed {
    logic [STROBE_FW-1:0] strobe;
    logic [HOLD_FW-1:0]   hold;
  } late_cfg_t;
endpackage

// File: rtl/nrs_cfg_latch.sv
`timescale 1ns/1ps
module nrs_cfg_latch
  import nand_rd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  late_cfg_t cfg_i,
  output late_cfg_t cfg_o
);
  late_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (load_i) cfg_q <= cfg_i;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/nrs_phase_ctrl.sv
`timescale 1ns/1ps
module nrs_phase_ctrl
  import nand_rd_pkg::*;
#(
  parameter int unsigned SETUP_W  = SETUP_FW,
  parameter int unsigned STROBE_W = STROBE_FW,
  parameter int unsigned HOLD_W   = HOLD_FW,
  parameter int unsigned TURN_W   = TURN_FW
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                req_wr_i,
  input  logic [SETUP_W-1:0]  setup_i,
  input  logic [TURN_W-1:0]   turn_i,
  input  logic [STROBE_W-1:0] strobe_q_i,
  input  logic [HOLD_W-1:0]   hold_q_i,
  output phase_e              phase_nxt_o,
  output logic                accept_rd_o,
  output logic                capture_o,
  output logic                wr_go_o,
  output logic                busy_o
);
  localparam int unsigned W_A   = (SETUP_W > STROBE_W) ? SETUP_W : STROBE_W;
  localparam int unsigned W_B   = (HOLD_W > TURN_W) ? HOLD_W : TURN_W;
  localparam int unsigned CNT_W = (W_A > W_B) ? W_A : W_B;

  phase_e           phase_q, phase_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             last_rd_q, last_rd_nxt;
  logic             go_q, go_nxt;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    phase_nxt   = phase_q;
    cnt_nxt     = cnt_q;
    last_rd_nxt = last_rd_q;
    go_nxt      = 1'b0;
    capture_o   = 1'b0;
    accept_rd_o = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_i) begin
          if (req_wr_i) begin
            if (last_rd_q) begin
              phase_nxt = PH_TURN;
              cnt_nxt   = CNT_W'(turn_i);
            end else begin
              go_nxt = 1'b1;
            end
          end else begin
            accept_rd_o = 1'b1;
            phase_nxt   = PH_SETUP;
            cnt_nxt     = CNT_W'(setup_i);
          end
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          phase_nxt = PH_STROBE;
          cnt_nxt   = CNT_W'(strobe_q_i);
        end else begin
          cnt_nxt = cnt_q - CNT_W'(1);
        end
      end
      PH_STROBE: begin
        if (cnt_zero) begin
          phase_nxt = PH_HOLD;
          cnt_nxt   = CNT_W'(hold_q_i);
          capture_o = 1'b1;
        end else begin
          cnt_nxt = cnt_q - CNT_W'(1);
        end
      end
      PH_HOLD: begin
        if (cnt_zero) begin
          phase_nxt   = PH_IDLE;
          last_rd_nxt = 1'b1;
        end else begin
          cnt_nxt = cnt_q - CNT_W'(1);
        end
      end
      PH_TURN: begin
        if (cnt_zero) begin
          phase_nxt   = PH_IDLE;
          go_nxt      = 1'b1;
          last_rd_nxt = 1'b0;
        end else begin
          cnt_nxt = cnt_q - CNT_W'(1);
        end
      end
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      last_rd_q <= 1'b0;
      go_q      <= 1'b0;
    end else begin
      phase_q   <= phase_nxt;
      cnt_q     <= cnt_nxt;
      last_rd_q <= last_rd_nxt;
      go_q      <= go_nxt;
    end
  end

  assign phase_nxt_o = phase_nxt;
  assign wr_go_o     = go_q;
  assign busy_o      = (phase_q != PH_IDLE);

  AST_SETUP_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SETUP) |=> (phase_q inside {PH_SETUP, PH_STROBE})); // R2
  AST_STROBE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_STROBE) |=> (phase_q inside {PH_STROBE, PH_HOLD})); // R3
  AST_HOLD_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_HOLD) |=> (phase_q inside {PH_HOLD, PH_IDLE})); // R4
  AST_BUSY_REQ_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q inside {PH_SETUP, PH_STROBE}) |=> (phase_q != PH_IDLE)); // R7
endmodule

// File: rtl/nrs_pin_drv.sv
`timescale 1ns/1ps
module nrs_pin_drv
  import nand_rd_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  phase_e        phase_nxt_i,
  input  logic          accept_rd_i,
  input  logic          ale_bit_i,
  input  logic          cle_bit_i,
  input  logic          capture_i,
  input  logic [DW-1:0] flash_d_i,
  output logic          cs_no,
  output logic          oe_no,
  output logic          ale_o,
  output logic          cle_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o
);
  logic          cs_q, oe_q, ale_q, cle_q, done_q;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q    <= 1'b1;
      oe_q    <= 1'b1;
      ale_q   <= 1'b0;
      cle_q   <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      cs_q   <= !(phase_nxt_i inside {PH_SETUP, PH_STROBE, PH_HOLD});
      oe_q   <= (phase_nxt_i != PH_STROBE);
      done_q <= capture_i;
      if (accept_rd_i) begin
        ale_q <= ale_bit_i;
        cle_q <= cle_bit_i;
      end
      if (capture_i) rdata_q <= flash_d_i;
    end
  end

  assign cs_no   = cs_q;
  assign oe_no   = oe_q;
  assign ale_o   = ale_q;
  assign cle_o   = cle_q;
  assign done_o  = done_q;
  assign rdata_o = rdata_q;

  AST_OE_INSIDE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_q |-> !cs_q); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R5
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (oe_q && !$past(oe_q) && !cs_q)); // R5
  AST_LATCH_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_q && $past(!cs_q)) |-> ($stable(ale_q) && $stable(cle_q))); // R6
endmodule

// File: rtl/nand_rd_seq.sv
`timescale 1ns/1ps
module nand_rd_seq
  import nand_rd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned ALE_BIT  = 1,
  parameter int unsigned CLE_BIT  = 2,
  parameter int unsigned SETUP_W  = SETUP_FW,
  parameter int unsigned STROBE_W = STROBE_FW,
  parameter int unsigned HOLD_W   = HOLD_FW,
  parameter int unsigned TURN_W   = TURN_FW,
  parameter int unsigned DW       = DATA_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                req_wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [SETUP_W-1:0]  setup_cfg_i,
  input  logic [STROBE_W-1:0] strobe_cfg_i,
  input  logic [HOLD_W-1:0]   hold_cfg_i,
  input  logic [TURN_W-1:0]   turn_cfg_i,
  input  logic [DW-1:0]       flash_d_i,
  output logic                cs_no,
  output logic                oe_no,
  output logic                ale_o,
  output logic                cle_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [DW-1:0]       rdata_o,
  output logic                wr_go_o
);
  late_cfg_t cfg_live, cfg_q;
  phase_e    phase_nxt;
  logic      accept_rd, capture;
  logic      unused_addr;

  assign unused_addr     = ^addr_i;
  assign cfg_live.strobe = strobe_cfg_i;
  assign cfg_live.hold   = hold_cfg_i;

  nrs_cfg_latch i_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept_rd),
    .cfg_i  (cfg_live),
    .cfg_o  (cfg_q)
  );

  nrs_phase_ctrl #(
    .SETUP_W  (SETUP_W),
    .STROBE_W (STROBE_W),
    .HOLD_W   (HOLD_W),
    .TURN_W   (TURN_W)
  ) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .req_wr_i    (req_wr_i),
    .setup_i     (setup_cfg_i),
    .turn_i      (turn_cfg_i),
    .strobe_q_i  (cfg_q.strobe),
    .hold_q_i    (cfg_q.hold),
    .phase_nxt_o (phase_nxt),
    .accept_rd_o (accept_rd),
    .capture_o   (capture),
    .wr_go_o     (wr_go_o),
    .busy_o      (busy_o)
  );

  nrs_pin_drv #(.DW(DW)) i_pins (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_nxt_i (phase_nxt),
    .accept_rd_i (accept_rd),
    .ale_bit_i   (addr_i[ALE_BIT]),
    .cle_bit_i   (addr_i[CLE_BIT]),
    .capture_i   (capture),
    .flash_d_i   (flash_d_i),
    .cs_no       (cs_no),
    .oe_no       (oe_no),
    .ale_o       (ale_o),
    .cle_o       (cle_o),
    .done_o      (done_o),
    .rdata_o     (rdata_o)
  );

  AST_CS_MEANS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> busy_o); // R7
  AST_GO_BUS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_go_o |-> (cs_no && oe_no && !busy_o)); // R8
  AST_GO_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_go_o |=> !wr_go_o); // R9
endmodule

// File: tb/test_nand_rd_seq.sv
`timescale 1ns/1ps
module test_nand_rd_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0, req_wr_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic [3:0] setup_cfg_i = '0;
  logic [5:0] strobe_cfg_i = '0;
  logic [2:0] hold_cfg_i = '0;
  logic [1:0] turn_cfg_i = '0;
  logic [7:0] fl_byte = 8'h00;
  logic [7:0] flash_d_i;
  logic       cs_no, oe_no, ale_o, cle_o, busy_o, done_o, wr_go_o;
  logic [7:0] rdata_o;

  int n_vec = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  typedef struct packed { int len; int oe_len; bit ale; bit cle; } win_t;
  typedef struct packed { logic [7:0] d; int at; } done_t;
  win_t  win_q[$];
  done_t done_q[$];

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  // flash model: byte only while output-enable is low
  assign flash_d_i = oe_no ? 8'hFF : fl_byte;

  nand_rd_seq i_nand_rd_seq (
    .clk_i, .rst_ni, .req_i, .req_wr_i, .addr_i, .setup_cfg_i, .strobe_cfg_i,
    .hold_cfg_i, .turn_cfg_i, .flash_d_i, .cs_no, .oe_no, .ale_o, .cle_o,
    .busy_o, .done_o, .rdata_o, .wr_go_o
  );

  task automatic chk(input string r, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  // monitor / scoreboard
  int  run = 0, oe_run = 0;
  bit  m_ale, m_cle;
  always @(negedge clk_i) if (rst_ni) begin
    if (done_o) begin
      if (done_q.size() == 0) chk("R5 unexpected done", 1, 0);
      else begin
        done_t dt;
        dt = done_q.pop_front();
        chk("R5 captured byte", int'(rdata_o), int'(dt.d));
        chk("R5 done cycle", cyc, dt.at);
      end
    end
    if (!cs_no) begin
      if (run == 0) begin m_ale = ale_o; m_cle = cle_o; end
      run++;
      if (!oe_no) oe_run++;
    end else if (run > 0) begin
      if (win_q.size() == 0) chk("R7 unexpected cs window", 1, 0);
      else begin
        win_t w;
        w = win_q.pop_front();
        chk("R2/R4 cs low length", run, w.len);
        chk("R3 oe low length", oe_run, w.oe_len);
        chk("R6 ale level", int'(m_ale), int'(w.ale));
        chk("R6 cle level", int'(m_cle), int'(w.cle));
      end
      run = 0; oe_run = 0;
    end
  end

  // called at a negedge with the block idle; returns at the first idle negedge
  task automatic do_read(input logic [7:0] a, input int su, input int st,
                         input int ho, input logic [7:0] d, input bit chg, input bit poke);
    int tot;
    tot = (su + 1) + (st + 1) + (ho + 1);
    setup_cfg_i = 4'(su); strobe_cfg_i = 6'(st); hold_cfg_i = 3'(ho);
    addr_i = a; fl_byte = d; req_i = 1'b1; req_wr_i = 1'b0;
    win_q.push_back('{len: tot, oe_len: st + 1, ale: a[1], cle: a[2]});
    done_q.push_back('{d: d, at: cyc + su + st + 3});
    @(negedge clk_i);
    if (chg) begin  // R11
      setup_cfg_i = ~setup_cfg_i; strobe_cfg_i = ~strobe_cfg_i; hold_cfg_i = ~hold_cfg_i;
    end
    if (poke) begin req_i = 1'b1; addr_i = ~a; end  // R7: must be ignored
    else req_i = 1'b0;
    chk("R7 busy after accept", int'(busy_o), 1);
    chk("R2 cs low first cycle", int'(cs_no), 0);
    @(negedge clk_i);
    req_i = 1'b0;
    repeat (tot - 2) @(negedge clk_i);
    chk("R7 busy in last hold cycle", int'(busy_o), 1);
    @(negedge clk_i);
    chk("R7 busy low after hold", int'(busy_o), 0);
    chk("R4 cs released", int'(cs_no), 1);
  endtask

  task automatic do_write(input int tu, input bit gap);
    int exp_k;
    exp_k = gap ? tu + 2 : 1;
    turn_cfg_i = 2'(tu); req_i = 1'b1; req_wr_i = 1'b1;
    for (int k = 1; k <= exp_k; k++) begin
      @(negedge clk_i);
      if (k == 1) begin req_i = 1'b0; req_wr_i = 1'b0; end
      chk(gap ? "R8 wr_go timing" : "R9 wr_go timing", int'(wr_go_o), int'(k == exp_k));
      if (k < exp_k) chk("R8 busy in gap", int'(busy_o), 1);
      else chk(gap ? "R8 busy after gap" : "R9 busy stays low", int'(busy_o), 0);
    end
    @(negedge clk_i);
    chk("R8 wr_go single pulse", int'(wr_go_o), 0);
    chk("R8 cs idle", int'(cs_no), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 cs_no in reset", int'(cs_no), 1);
    chk("R1 oe_no in reset", int'(oe_no), 1);
    chk("R1 busy in reset", int'(busy_o), 0);
    chk("R1 done in reset", int'(done_o), 0);
    chk("R1 wr_go in reset", int'(wr_go_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    do_write(2, 0);                                  // R9 after reset
    do_read(8'h02, 0, 0, 0, 8'hA5, 0, 0);           // R12 minimum
    do_read(8'h04, 2, 5, 1, 8'h3C, 0, 0);           // R10 back to back
    do_read(8'h06, 15, 63, 7, 8'h81, 0, 0);         // R12 maximum
    do_write(2, 1);                                  // R8
    do_write(3, 0);                                  // R9 after write
    do_read(8'h00, 3, 2, 2, 8'h5A, 1, 0);           // R11
    do_write(0, 1);                                  // R8 shortest gap
    do_read(8'h06, 1, 3, 0, 8'hC3, 0, 1);           // R7 poke
    do_read(8'h02, 0, 1, 4, 8'h96, 0, 0);           // R10
    do_write(3, 1);                                  // R8 longest gap
    repeat (5) @(negedge clk_i);
    chk("R7 no stray window", win_q.size() + run, 0);
    chk("R5 no missing done", done_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule